// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This unit gathers the single-cycle event strobes that an I2C protocol engine raises and holds them as sticky flags in a status register. An enable register selects which flags may interrupt the host. A vector register returns a small code for the pending, enabled event of highest priority. When the host reads that vector, the reported flag is cleared. An interrupt service routine can therefore read the vector again and again, handling each event in priority order until the code reads 0.

Two more status bits are levels rather than events. One reports whether the bus is busy: it is set when a start is seen and released when a stop is seen. The other mirrors the receive shift register full indication from the engine. Neither of these takes part in the vector or the interrupt. Software can clear any event flag by writing ones to the status register.

Top module: `i2cev_unit`

## Requirements
- R1: After reset the mask, status and vector registers all read 0 and `irq` is low.
- R2: Each event pulse sets a sticky status flag. Arbitration lost sets bit 0, NACK bit 1, access ready bit 2, receive ready bit 3, transmit ready bit 4, stop detected bit 5 and addressed as target bit 6. The flag stays set until it is cleared.
- R3: Writing the status register clears each event flag whose data bit is 1, and data bits that are 0 leave their flags alone. If an event pulse and a clearing write hit the same flag in the same cycle, the flag stays set.
- R4: The mask register (address 0) holds bits 6:0, one enable per event in the same positions as the status flags. Mask bits 15:7 always read 0.
- R5: The vector register (address 2) returns the code of the pending, enabled event that has the lowest code. The codes are: arbitration lost 1, NACK 2, access ready 3, receive ready 4, transmit ready 5, stop detected 6, addressed as target 7. The vector reads 0 when no event is both pending and enabled.
- R6: A flag whose mask bit is 0 still shows in the status register but is passed over by the vector and by `irq`.
- R7: A read of the vector register clears the flag it reports, so successive reads step through the enabled pending events in code order and end at 0.
- R8: `irq` is high exactly when at least one status flag and its mask bit are both 1.
- R9: Status bit 12 is a read-only bus busy level. It is set by a start pulse and cleared by a stop detected pulse; if both arrive in the same cycle, the start wins. Writes do not change it, and it never produces a vector code or `irq`.
- R10: Status bit 11 follows the `rx_shift_full` input level.
- R11: The status register sits at address 1, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_nack | input | 1 | No-acknowledge pulse |
| ev_acc_rdy | input | 1 | Access ready pulse |
| ev_rx_rdy | input | 1 | Receive ready pulse |
| ev_tx_rdy | input | 1 | Transmit ready pulse |
| ev_stop_det | input | 1 | Stop detected pulse |
| ev_addr_tgt | input | 1 | Addressed as target pulse |
| ev_start_det | input | 1 | Start detected pulse (bus busy only) |
| rx_shift_full | input | 1 | Receive shift full level |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a vector read clears a flag) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid while `reg_rd` is high |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest case to reach from the ports is a pulse and a clearing write that land on the same flag in the same cycle. The stimulus gets there by driving the stop detected strobe in the exact cycle of a status write with bit 5 set. Walking the vector is also hard to reach, because it needs all seven flags pending together. The bench fires every event at once, then reads the vector eight times back to back. A second walk runs under a sparse mask, to show that disabled flags are skipped while they remain visible in the status register.

// File: rtl/i2cev_pkg.sv
package i2cev_pkg;
  localparam int NUM_EV = 7;
  localparam int CODE_W = $clog2(NUM_EV + 1);

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_STAT = 2'd1,
    SEL_VEC  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // code of the lowest set bit, counted from 1; 0 when nothing is set
  function automatic logic [CODE_W-1:0] first_code(input logic [NUM_EV-1:0] pend);
    logic [CODE_W-1:0] c;
    c = '0;
    for (int i = NUM_EV - 1; i >= 0; i--)
      if (pend[i]) c = CODE_W'(i + 1);
    return c;
  endfunction

  // one-hot of the lowest set bit
  function automatic logic [NUM_EV-1:0] lowest_bit(input logic [NUM_EV-1:0] pend);
    return pend & (~pend + NUM_EV'(1));
  endfunction
endpackage

// File: rtl/i2cev_flag_bank.sv
module i2cev_flag_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags_o[i] <= 1'b0;
      else if (set_i[i])    flags_o[i] <= 1'b1;
      else if (clr_i[i])    flags_o[i] <= 1'b0;
    end

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flags_o[i]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flags_o[i]);
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o[i] && !clr_i[i]) |=> flags_o[i]);
  end
endmodule

// File: rtl/i2cev_prio_pick.sv
module i2cev_prio_pick
  import i2cev_pkg::*;
#(
  parameter int N  = NUM_EV,
  parameter int CW = CODE_W
) (
  input  logic [N-1:0]  pend_i,
  output logic [N-1:0]  grant_o,
  output logic [CW-1:0] code_o
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant_o[i]    = pend_i[i] && !blocked[i];
    assign blocked[i+1]  = blocked[i] || pend_i[i];
  end

  assign code_o = first_code(pend_i);

  always_comb begin
    p_grant_onehot_r5: assert ($onehot0(grant_o));
    p_grant_in_pend_r5: assert ((grant_o & ~pend_i) == '0);
    p_code_zero_r5: assert ((code_o == '0) == (pend_i == '0));
    p_grant_lowest_r5: assert (grant_o == lowest_bit(pend_i));
  end
endmodule

// File: rtl/i2cev_bus_track.sv
module i2cev_bus_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic stop_i,
  output logic busy_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_o <= 1'b0;
    else if (start_i) busy_o <= 1'b1;
    else if (stop_i)  busy_o <= 1'b0;
  end

  p_busy_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> busy_o);
  p_busy_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !busy_o);
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !stop_i) |=> $stable(busy_o));
endmodule

// File: rtl/i2cev_unit.sv
module i2cev_unit
  import i2cev_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int RSF_BIT  = 11,
  parameter int BUSY_BIT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_arb_lost,
  input  logic             ev_nack,
  input  logic             ev_acc_rdy,
  input  logic             ev_rx_rdy,
  input  logic             ev_tx_rdy,
  input  logic             ev_stop_det,
  input  logic             ev_addr_tgt,
  input  logic             ev_start_det,
  input  logic             rx_shift_full,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  localparam int N = NUM_EV;

  reg_sel_e        sel;
  logic [N-1:0]    ev_vec;
  logic [N-1:0]    mask_q;
  logic [N-1:0]    flags;
  logic [N-1:0]    pending;
  logic [N-1:0]    grant;
  logic [CODE_W-1:0] code;
  logic [N-1:0]    clr_wr;
  logic [N-1:0]    clr_vec;
  logic            busy;
  logic            vec_take;
  logic            stat_wr;
  logic            mask_wr;
  logic [REG_W-1:0] stat_word;
  logic            unused_wbits;

  assign sel    = reg_sel_e'(reg_addr);
  assign ev_vec = {ev_addr_tgt, ev_stop_det, ev_tx_rdy, ev_rx_rdy,
                   ev_acc_rdy, ev_nack, ev_arb_lost};

  assign mask_wr  = reg_wr && (sel == SEL_MASK);
  assign stat_wr  = reg_wr && (sel == SEL_STAT);
  assign vec_take = reg_rd && (sel == SEL_VEC);
  assign unused_wbits = ^reg_wdata[REG_W-1:N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= reg_wdata[N-1:0];
  end

  assign clr_wr  = stat_wr  ? reg_wdata[N-1:0] : '0;
  assign clr_vec = vec_take ? grant : '0;

  i2cev_flag_bank #(.N(N)) i_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (ev_vec),
    .clr_i   (clr_wr | clr_vec),
    .flags_o (flags)
  );

  assign pending = flags & mask_q;

  i2cev_prio_pick #(.N(N), .CW(CODE_W)) i_pick (
    .pend_i  (pending),
    .grant_o (grant),
    .code_o  (code)
  );

  i2cev_bus_track i_busy (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (ev_start_det),
    .stop_i  (ev_stop_det),
    .busy_o  (busy)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[N-1:0]    = flags;
    stat_word[RSF_BIT]  = rx_shift_full;
    stat_word[BUSY_BIT] = busy;
  end

  always_comb begin
    unique case (sel)
      SEL_MASK: reg_rdata = REG_W'(mask_q);
      SEL_STAT: reg_rdata = stat_word;
      SEL_VEC:  reg_rdata = REG_W'(code);
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = |pending;

  p_irq_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != '0));
  p_vec_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_take && code != '0 && ev_vec == '0 && !stat_wr)
      |=> $countones(flags) == $countones($past(flags)) - 1);
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));
endmodule

// File: tb/test_i2cev_unit.sv
`timescale 1ns/1ps
module test_i2cev_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  ev = '0;
  logic        ev_start = 1'b0;
  logic        rsf = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;
  int    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  i2cev_unit i_i2cev_unit (
    .clk(clk), .rst_n(rst_n),
    .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]),
    .ev_rx_rdy(ev[3]), .ev_tx_rdy(ev[4]), .ev_stop_det(ev[5]),
    .ev_addr_tgt(ev[6]), .ev_start_det(ev_start),
    .rx_shift_full(rsf), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  // monitor: pops one expected item per read cycle
  always @(negedge clk) begin
    if (reg_rd) begin
      if (exp_q.size() == 0) begin
        nerr++;
        $display("FAIL unexpected read: got %h", reg_rdata);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        nchk++;
        if (reg_rdata !== 16'(e)) begin
          nerr++;
          $display("FAIL %s: got %h expected %h", t, reg_rdata, 16'(e));
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input int e, input string t);
    @(posedge clk); #1;
    reg_addr = a; reg_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [6:0] m, input logic st);
    @(posedge clk); #1;
    ev = m; ev_start = st;
    @(posedge clk); #1;
    ev = '0; ev_start = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    nchk++;
    if (irq !== e) begin
      nerr++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    nerr++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(2'd0, 0, "R1 mask after reset");
    rd(2'd1, 0, "R1 status after reset");
    rd(2'd2, 0, "R1 vector after reset");
    chk_irq(1'b0, "R1 irq after reset");

    // R2 / R6: flag set while disabled
    pulse(7'h01, 1'b0);
    rd(2'd1, 16'h0001, "R2 arbitration lost at bit 0");
    rd(2'd2, 0, "R6 disabled flag not in vector");
    chk_irq(1'b0, "R6 disabled flag no irq");

    // R4 mask
    wr(2'd0, 16'hFFFF);
    rd(2'd0, 16'h007F, "R4 mask upper bits read 0");
    chk_irq(1'b1, "R8 irq once enabled");

    // R5 / R7 full walk
    pulse(7'h7E, 1'b0);
    rd(2'd1, 16'h007F, "R2 all event flags");
    for (int k = 1; k <= 7; k++) rd(2'd2, k, "R5 R7 vector walk");
    rd(2'd2, 0, "R7 walk ends at 0");
    rd(2'd1, 0, "R7 walk cleared all flags");
    chk_irq(1'b0, "R8 irq low when empty");

    // R6 sparse mask
    wr(2'd0, 16'h0014);
    pulse(7'h16, 1'b0);
    chk_irq(1'b1, "R8 irq with enabled flags");
    rd(2'd2, 3, "R6 access ready first");
    rd(2'd2, 5, "R6 transmit ready next");
    rd(2'd2, 0, "R6 nack skipped");
    rd(2'd1, 16'h0002, "R6 nack still in status");
    chk_irq(1'b0, "R8 irq low with only disabled flag");

    // R3 write-one-to-clear
    wr(2'd1, 16'h0000);
    rd(2'd1, 16'h0002, "R3 zero write keeps flag");
    wr(2'd1, 16'h0002);
    rd(2'd1, 16'h0000, "R3 one write clears flag");
    @(posedge clk); #1;
    reg_addr = 2'd1; reg_wr = 1'b1; reg_wdata = 16'h0020; ev = 7'h20;
    @(posedge clk); #1;
    reg_wr = 1'b0; ev = '0;
    rd(2'd1, 16'h0020, "R3 set wins over clear");
    wr(2'd1, 16'h0020);

    // R9 bus busy
    wr(2'd0, 16'h007F);
    pulse(7'h00, 1'b1);
    rd(2'd1, 16'h1000, "R9 busy after start");
    rd(2'd2, 0, "R9 busy not in vector");
    chk_irq(1'b0, "R9 busy no irq");
    wr(2'd1, 16'hFFFF);
    rd(2'd1, 16'h1000, "R9 busy ignores write");
    pulse(7'h20, 1'b1);
    rd(2'd1, 16'h1020, "R9 start wins over stop");
    wr(2'd1, 16'h0020);
    pulse(7'h20, 1'b0);
    rd(2'd1, 16'h0020, "R9 stop clears busy");

    // R10 / R11
    rsf = 1'b1;
    rd(2'd1, 16'h0820, "R10 shift full bit 11");
    rsf = 1'b0;
    rd(2'd1, 16'h0020, "R10 shift full follows level");
    rd(2'd3, 0, "R11 unused address reads 0");

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule